// File: doc/BRIEF.md
# Microprogram Sequencer with Flag and Opcode Branching

This block steps through a microprogram held in a writable control store. The store has 512 words of 36 bits. A 9-bit microprogram counter (MPC) selects the current word, and that word is held in a microinstruction register (MIR). The MIR's control fields drive the ALU and shifter, the register-write enables, the memory strobes and the encoded source select of a datapath outside this block. The block has no incrementer. Each word carries the address of the word that follows it. A 3-bit jump field can modify that address in two ways. Either of two status flags can be merged into the top address bit, which gives two-way branches. The opcode byte from the memory buffer can be merged into the low eight bits, which gives a dispatch across up to 256 targets in one cycle.

The controller has two named states. In HALT, the MPC and the MIR are held at zero, and the control store can be loaded through a synchronous write port. The transition START (HALT to RUN) occurs on the first rising edge with `run_en` high. It fetches word 0. In RUN, each rising edge computes the successor address and loads the MIR from that address. The transition STOP (RUN to HALT) occurs on an edge with `run_en` low. The flag and opcode inputs that the edge samples are the values produced by the microinstruction that this edge retires.

Top module: `microseq`

## Requirements
- R1: While `rst_n` is low, `mpc` is 0, every control output is 0, and the controller is in HALT.
- R2: On every edge with `run_en` low, `mpc` and all control outputs become 0. Control-store writes made in this state leave the outputs at 0.
- R3: On the START edge, the MIR is loaded from word 0 and `mpc` reads 0. The fields of the word are: bits 35:27 next address; bit 26 opcode-jump; bit 25 N-jump; bit 24 Z-jump; bits 23:16 `alu_ctl`; bits 15:7 `c_sel`; bits 6:4 `mem_ctl`; bits 3:0 `b_sel`.
- R4: When all three jump bits are 0, the next MPC equals the next-address field. `n_flag`, `z_flag` and `mbr_op` have no effect on it.
- R5: Bit 8 of the next MPC is the OR of next-address bit 8, (N-jump AND `n_flag`) and (Z-jump AND `z_flag`). Without the opcode-jump bit, bits 7:0 are copied from the field.
- R6: When the opcode-jump bit is set, bits 7:0 of the next MPC are the field's bits 7:0 ORed with `mbr_op`.
- R7: In RUN, after every edge the control outputs equal the fields of the store word at the new `mpc`.
- R8: On the STOP edge, the controller returns to HALT with `mpc` 0. A later START resumes from word 0.
- R9: A store write takes effect at the edge on which `cs_we` is high. A later write to the same address replaces the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | High to execute the microprogram; low to halt |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 9 | Control-store write address |
| cs_wdata | input | 36 | Control-store write data |
| n_flag | input | 1 | Negative flag of the retiring microinstruction |
| z_flag | input | 1 | Zero flag of the retiring microinstruction |
| mbr_op | input | 8 | Opcode byte for the multiway jump |
| mpc | output | 9 | Current microprogram counter |
| alu_ctl | output | 8 | ALU and shifter control field |
| c_sel | output | 9 | Register-write enable field |
| mem_ctl | output | 3 | Memory strobe field |
| b_sel | output | 4 | Encoded source-select field |

## Verification
The hardest case to reach is a word whose jump bits overlap bits that are already set in its own next-address field. Examples are an opcode byte ORed onto a nonzero low field, or a flag merged into an address whose bit 8 is already 1. A plain microprogram seldom reaches such a word by chance. A directed chain of store words leads the sequencer through each of these cases in turn. After that chain, thousands of cycles run over a store filled with random words, with random flags and opcode bytes each cycle. This exercises every combination of jump bits and addresses spread across the whole store. A STOP and a restart after rewriting word 0 follow at the end.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } useq_state_e;

    localparam int JAM_W    = 3;
    localparam int JMPC_BIT = 2;
    localparam int JAMN_BIT = 1;
    localparam int JAMZ_BIT = 0;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int AW = 9,
    parameter int DW = 36,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/useq_next.sv
module useq_next #(
    parameter int NA_W = 9,
    localparam int OP_W = NA_W - 1
) (
    input  logic [NA_W-1:0] base_addr,
    input  logic            jmpc,
    input  logic            jamn,
    input  logic            jamz,
    input  logic            n_flag,
    input  logic            z_flag,
    input  logic [OP_W-1:0] opcode,
    output logic [NA_W-1:0] next_addr
);

    // Low bits: optional merge of the opcode byte for dispatch.
    for (genvar i = 0; i < OP_W; i++) begin : g_low
        assign next_addr[i] = base_addr[i] | (jmpc & opcode[i]);
    end

    // Top bit: optional merge of the selected flags for two-way branches.
    assign next_addr[NA_W-1] = base_addr[NA_W-1]
                             | (jamn & n_flag)
                             | (jamz & z_flag);

endmodule

// File: rtl/microseq.sv
module microseq
    import useq_pkg::*;
#(
    parameter int NA_W  = 9,
    parameter int ALU_W = 8,
    parameter int C_W   = 9,
    parameter int MEM_W = 3,
    parameter int B_W   = 4,
    localparam int OP_W    = NA_W - 1,
    localparam int B_LSB   = 0,
    localparam int MEM_LSB = B_LSB + B_W,
    localparam int C_LSB   = MEM_LSB + MEM_W,
    localparam int ALU_LSB = C_LSB + C_W,
    localparam int JAM_LSB = ALU_LSB + ALU_W,
    localparam int NA_LSB  = JAM_LSB + JAM_W,
    localparam int W       = NA_LSB + NA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cs_we,
    input  logic [NA_W-1:0]  cs_waddr,
    input  logic [W-1:0]     cs_wdata,
    input  logic             n_flag,
    input  logic             z_flag,
    input  logic [OP_W-1:0]  mbr_op,
    output logic [NA_W-1:0]  mpc,
    output logic [ALU_W-1:0] alu_ctl,
    output logic [C_W-1:0]   c_sel,
    output logic [MEM_W-1:0] mem_ctl,
    output logic [B_W-1:0]   b_sel
);

    useq_state_e     state_q, state_d;
    logic [NA_W-1:0] mpc_q;
    logic [W-1:0]    mir_q;
    logic [NA_W-1:0] succ_addr;
    logic [NA_W-1:0] fetch_addr;
    logic [W-1:0]    store_word;
    logic            running;

    assign running = (state_q == ST_RUN);

    useq_store #(.AW(NA_W), .DW(W)) u_store (
        .clk   (clk),
        .we    (cs_we),
        .waddr (cs_waddr),
        .wdata (cs_wdata),
        .raddr (fetch_addr),
        .rdata (store_word)
    );

    useq_next #(.NA_W(NA_W)) u_next (
        .base_addr (mir_q[NA_LSB +: NA_W]),
        .jmpc      (mir_q[JAM_LSB + JMPC_BIT]),
        .jamn      (mir_q[JAM_LSB + JAMN_BIT]),
        .jamz      (mir_q[JAM_LSB + JAMZ_BIT]),
        .n_flag    (n_flag),
        .z_flag    (z_flag),
        .opcode    (mbr_op),
        .next_addr (succ_addr)
    );

    // START fetches word 0; RUN fetches the computed successor.
    always_comb begin
        unique case (state_q)
            ST_HALT: fetch_addr = '0;
            ST_RUN:  fetch_addr = succ_addr;
            default: fetch_addr = '0;
        endcase
    end

    // Transitions: START (HALT->RUN), STOP (RUN->HALT).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_en)  state_d = ST_RUN;
            ST_RUN:  if (!run_en) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers: MPC and MIR.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mpc_q <= '0;
            mir_q <= '0;
        end else if (!run_en) begin
            mpc_q <= '0;
            mir_q <= '0;
        end else begin
            mpc_q <= fetch_addr;
            mir_q <= store_word;
        end
    end

    assign mpc     = mpc_q;
    assign alu_ctl = mir_q[ALU_LSB +: ALU_W];
    assign c_sel   = mir_q[C_LSB +: C_W];
    assign mem_ctl = mir_q[MEM_LSB +: MEM_W];
    assign b_sel   = mir_q[B_LSB +: B_W];

endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
#(
    parameter int NA_W  = 9,
    parameter int ALU_W = 8,
    parameter int C_W   = 9,
    parameter int MEM_W = 3,
    parameter int B_W   = 4,
    localparam int OP_W    = NA_W - 1,
    localparam int JAM_LSB = B_W + MEM_W + C_W + ALU_W,
    localparam int NA_LSB  = JAM_LSB + JAM_W,
    localparam int W       = NA_LSB + NA_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            n_flag,
    input logic            z_flag,
    input logic [OP_W-1:0] mbr_op,
    input logic [NA_W-1:0] mpc,
    input logic [W-1:0]    mir,
    input logic            running
);

    logic            stepping;
    logic            jm, jn, jz;
    logic [NA_W-1:0] na;

    assign stepping = running && run_en;
    assign jm = mir[JAM_LSB + JMPC_BIT];
    assign jn = mir[JAM_LSB + JAMN_BIT];
    assign jz = mir[JAM_LSB + JAMZ_BIT];
    assign na = mir[NA_LSB +: NA_W];

    a_r2_halt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (mpc == '0 && mir == '0 && !running));

    a_r4_plain_next: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !jm && !jn && !jz) |=> (mpc == $past(na)));

    a_r5_top_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !jn && !jz) |=> (mpc[NA_W-1] == $past(na[NA_W-1])));

    a_r5_n_sets_top: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && jn && n_flag) |=> mpc[NA_W-1]);

    a_r5_z_sets_top: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && jz && z_flag) |=> mpc[NA_W-1]);

    a_r6_low_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && !jm) |=> (mpc[OP_W-1:0] == $past(na[OP_W-1:0])));

    a_r6_opcode_merged: assert property (@(posedge clk) disable iff (!rst_n)
        (stepping && jm) |=> ((mpc[OP_W-1:0] & $past(mbr_op)) == $past(mbr_op)));

    a_r8_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && run_en) |=> (running && mpc == '0));

endmodule

bind microseq useq_chk #(
    .NA_W(NA_W), .ALU_W(ALU_W), .C_W(C_W), .MEM_W(MEM_W), .B_W(B_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .n_flag  (n_flag),
    .z_flag  (z_flag),
    .mbr_op  (mbr_op),
    .mpc     (mpc),
    .mir     (mir_q),
    .running (running)
);

// File: tb/microseq_tb.sv
module microseq_tb;

    localparam int NA_W  = 9;
    localparam int W     = 36;
    localparam int DEPTH = 512;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          run_en;
    logic          cs_we;
    logic [8:0]    cs_waddr;
    logic [W-1:0]  cs_wdata;
    logic          n_flag, z_flag;
    logic [7:0]    mbr_op;
    logic [8:0]    mpc;
    logic [7:0]    alu_ctl;
    logic [8:0]    c_sel;
    logic [2:0]    mem_ctl;
    logic [3:0]    b_sel;

    logic [W-1:0]  model [DEPTH];
    logic [8:0]    exp_mpc;
    int            vectors = 0;
    int            fails   = 0;
    bit            done    = 1'b0;

    always #4 clk = ~clk;

    microseq u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cs_we(cs_we),
        .cs_waddr(cs_waddr), .cs_wdata(cs_wdata), .n_flag(n_flag),
        .z_flag(z_flag), .mbr_op(mbr_op), .mpc(mpc), .alu_ctl(alu_ctl),
        .c_sel(c_sel), .mem_ctl(mem_ctl), .b_sel(b_sel)
    );

    function automatic logic [W-1:0] mk(input logic [8:0] na, input logic jm,
                                        input logic jn, input logic jz,
                                        input logic [7:0] alu, input logic [8:0] c,
                                        input logic [2:0] m, input logic [3:0] b);
        return {na, jm, jn, jz, alu, c, m, b};
    endfunction

    function automatic logic [8:0] calc_next(input logic [W-1:0] w, input logic n,
                                             input logic z, input logic [7:0] op);
        logic [8:0] r;
        r = w[35:27];
        r[8] = r[8] | (w[25] & n) | (w[24] & z);
        if (w[26]) r[7:0] = r[7:0] | op;
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_fields(input string tag, input logic [W-1:0] w);
        check(tag, 64'(alu_ctl), 64'(w[23:16]), "alu_ctl");
        check(tag, 64'(c_sel),   64'(w[15:7]),  "c_sel");
        check(tag, 64'(mem_ctl), 64'(w[6:4]),   "mem_ctl");
        check(tag, 64'(b_sel),   64'(w[3:0]),   "b_sel");
    endtask

    task automatic wr(input logic [8:0] a, input logic [W-1:0] d);
        @(negedge clk);
        cs_we = 1'b1; cs_waddr = a; cs_wdata = d;
        model[a] = d;
        @(posedge clk);
        #1 cs_we = 1'b0;
    endtask

    // Called at a negedge: drive inputs, wait one edge, check.
    task automatic step(input logic n, input logic z, input logic [7:0] op);
        logic [W-1:0] cur;
        logic [8:0]   nxt;
        string        tag;
        cur = model[exp_mpc];
        tag = cur[26] ? "R6" : ((cur[25] | cur[24]) ? "R5" : "R4");
        nxt = calc_next(cur, n, z, op);
        n_flag = n; z_flag = z; mbr_op = op;
        @(negedge clk);
        check(tag, 64'(mpc), 64'(nxt), "mpc");
        exp_mpc = nxt;
        check_fields("R7", model[exp_mpc]);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0; run_en = 1'b0; cs_we = 1'b0; cs_waddr = '0; cs_wdata = '0;
        n_flag = 1'b0; z_flag = 1'b0; mbr_op = '0;
        repeat (3) @(negedge clk);
        check("R1", 64'(mpc), 64'd0, "mpc in reset");
        check_fields("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 64'(mpc), 64'd0, "mpc after reset");

        // Preload random words, then a directed chain.
        for (int a = 0; a < DEPTH; a++) begin
            wr(9'(a), {$urandom, $urandom}[W-1:0]);
        end
        wr(9'h000, mk(9'h1AB, 1'b1, 1'b1, 1'b1, 8'hEE, 9'h1EE, 3'h7, 4'hE));
        wr(9'h000, mk(9'h005, 1'b0, 1'b0, 1'b0, 8'h11, 9'h022, 3'h1, 4'h3)); // R9 last wins
        wr(9'h005, mk(9'h010, 1'b0, 1'b1, 1'b0, 8'h22, 9'h044, 3'h2, 4'h5));
        wr(9'h110, mk(9'h020, 1'b0, 1'b0, 1'b1, 8'h33, 9'h088, 3'h4, 4'h6));
        wr(9'h020, mk(9'h100, 1'b0, 1'b0, 1'b1, 8'h44, 9'h101, 3'h3, 4'h7));
        wr(9'h100, mk(9'h000, 1'b1, 1'b0, 1'b0, 8'h55, 9'h0F0, 3'h5, 4'h8));
        wr(9'h0A7, mk(9'h1F0, 1'b1, 1'b0, 1'b0, 8'h66, 9'h00F, 3'h6, 4'h9));
        wr(9'h1FF, mk(9'h0FF, 1'b1, 1'b1, 1'b1, 8'h77, 9'h1FF, 3'h0, 4'hA));
        @(negedge clk);
        check("R2", 64'(mpc), 64'd0, "mpc after writes while halted");
        check_fields("R2", '0);

        run_en = 1'b1;
        @(negedge clk);
        exp_mpc = '0;
        check("R3", 64'(mpc), 64'd0, "mpc at start");
        check_fields("R3", model[0]);
        check("R9", 64'(b_sel), 64'h3, "rewritten word 0");

        step(1'b1, 1'b1, 8'hFF);   // R4 plain: -> 005 despite flags and opcode
        step(1'b1, 1'b0, 8'h00);   // R5 N merges: -> 110
        step(1'b1, 1'b0, 8'h3C);   // R5 Z clear, N not selected: -> 020
        step(1'b0, 1'b1, 8'h00);   // R5 Z merges onto already-set top bit: -> 100
        step(1'b0, 1'b0, 8'hA7);   // R6 dispatch: -> 0A7
        step(1'b0, 1'b0, 8'h0F);   // R6 overlap with field bits: -> 1FF
        step(1'b1, 1'b0, 8'h00);   // R5/R6 combined: -> 1FF
        check("R6", 64'(mpc), 64'h1FF, "directed chain end");

        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom), 1'($urandom), 8'($urandom));
        end

        run_en = 1'b0;
        @(negedge clk);
        check("R8", 64'(mpc), 64'd0, "mpc after stop");
        check_fields("R8", '0);
        wr(9'h000, mk(9'h0C3, 1'b1, 1'b0, 1'b1, 8'h9A, 9'h155, 3'h2, 4'hC));
        @(negedge clk);
        check("R2", 64'(mpc), 64'd0, "mpc after halted rewrite");
        check_fields("R2", '0);

        run_en = 1'b1;
        @(negedge clk);
        exp_mpc = '0;
        check("R8", 64'(mpc), 64'd0, "mpc at restart");
        check_fields("R8", model[0]);
        for (int i = 0; i < 200; i++) begin
            step(1'($urandom), 1'($urandom), 8'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule